// File: doc/BRIEF.md
# Paired General Register File

This block stores an 8-bit accumulator and six 8-bit general registers, named B, C, D, E, H and L. The six general registers also work as three 16-bit pairs: B-C, D-E and H-L. In each pair the first-named register is the high byte. A datapath reads single registers and pairs through combinational ports. It writes one byte through a register write port. A pair operation port rewrites a whole pair in one cycle.

The pair operation port handles these operations:
- a direct 16-bit write,
- a load from two immediate bytes,
- a swap of H-L with D-E,
- a 16-bit increment or decrement,
- an add of a pair into H-L that records a carry.

A separate selector drives a 16-bit memory address output from H-L, B-C or D-E. H-L is the general memory pointer. B-C and D-E serve indirect loads and stores.

All writes take effect at the rising clock edge. All reads, the memory address output and the carry output show the stored state.

Top module: `pair_regfile`

## Requirements
- R1: Synchronous active-low reset clears the accumulator, all six general registers and the carry output to zero.
- R2: Register codes are B=0, C=1, D=2, E=3, H=4, L=5, accumulator=7. A register write stores the data in the coded register at the next edge, and a read returns it combinationally. Code 6 reads as 00h, and a write to code 6 changes nothing.
- R3: A move can be done as a read of one code followed by a write of that value to another code. It copies the value and leaves the source register unchanged.
- R4: Pair codes are B-C=0, D-E=1, H-L=2. A pair read returns {high register, low register}, and pair code 3 reads 0000h. Pair operation code 1 writes the 16-bit data into the selected pair.
- R5: Pair operation code 2 loads the selected pair. The low immediate byte goes to the low register and the high immediate byte goes to the high register, so B-C with bytes 00h and D5h gives B=D5h and C=00h.
- R6: Pair operation code 3 swaps H with D and L with E in one cycle, whatever the pair code.
- R7: Pair operation codes 4 and 5 increment and decrement the selected pair as one 16-bit value, wrapping modulo 2^16. They leave the carry output unchanged.
- R8: Pair operation code 6 adds the selected pair into H-L. It stores the low 16 bits of the sum in H-L and the seventeenth bit in the carry output. No other operation changes the carry output.
- R9: Memory select codes are H-L=0, B-C=1, D-E=2, H-L=3. The memory address output shows the selected pair.
- R10: If a register write and a pair operation target the same pair in one cycle, the pair operation result is stored. A register write to any register outside the pairs being written still takes effect.
- R11: Pair operation codes 1, 2, 4, 5 and 6 with pair code 3 change no register and no carry. Operation codes 0 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_rd_sel | input | 3 | Register read code |
| reg_rd_data | output | 8 | Register read value |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_sel | input | 3 | Register write code |
| reg_wr_data | input | 8 | Register write value |
| pair_rd_sel | input | 2 | Pair read code |
| pair_rd_data | output | 16 | Pair read value |
| pair_op | input | 3 | Pair operation code |
| pair_sel | input | 2 | Pair operated on |
| pair_wr_data | input | 16 | Data for the direct pair write |
| imm_lo | input | 8 | Low immediate byte |
| imm_hi | input | 8 | High immediate byte |
| mem_sel | input | 2 | Memory address source code |
| mem_addr | output | 16 | Memory address |
| carry_out | output | 1 | Carry from the last pair add |

## Verification
The hardest case to reach is a collision: a register write and a pair operation that touch the same pair in the same cycle. Both ports must be active together and their targets must overlap.

The random phase draws the register write and the pair operation independently on every step, so overlaps with swaps, adds and steps occur often. Directed steps add the exact collisions, the 16-bit wrap at both ends, an add that carries and one that does not, and operations aimed at the unused pair code.

// File: rtl/pair_regfile_pkg.sv
// Shared encodings for the paired register file.
// Assumes byte codes B,C,D,E,H,L = 0..5 so that code>>1 is the pair index.
package pair_regfile_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PUT   = 3'd1,
        OP_IMM   = 3'd2,
        OP_SWAP  = 3'd3,
        OP_INC   = 3'd4,
        OP_DEC   = 3'd5,
        OP_ADDHL = 3'd6,
        OP_RSVD  = 3'd7
    } pair_op_e;

    localparam int          NUM_PAIRS = 3;
    localparam logic [1:0]  PR_BC     = 2'd0;
    localparam logic [1:0]  PR_DE     = 2'd1;
    localparam logic [1:0]  PR_HL     = 2'd2;
    localparam logic [1:0]  PR_NONE   = 2'd3;
    localparam logic [2:0]  SEL_VOID  = 3'd6;
    localparam logic [2:0]  SEL_ACC   = 3'd7;
endpackage

// File: rtl/pair_alu.sv
// Combinational pair operation unit: from the current pair values it
// computes which pairs change, their next values, and the carry update.
// Assumes at most one operation per cycle; pair code 3 selects nothing.
module pair_alu
    import pair_regfile_pkg::*;
#(
    parameter int W = 8
) (
    input  pair_op_e                        op,
    input  logic [1:0]                      sel,
    input  logic [NUM_PAIRS-1:0][2*W-1:0]   cur,
    input  logic [W-1:0]                    imm_lo,
    input  logic [W-1:0]                    imm_hi,
    input  logic [2*W-1:0]                  wdata,
    output logic [NUM_PAIRS-1:0]            we,
    output logic [NUM_PAIRS-1:0][2*W-1:0]   nxt,
    output logic                            cy_we,
    output logic                            cy_val
);
    localparam int PW = 2 * W;

    logic          sel_ok;
    logic [1:0]    idx;
    logic [PW-1:0] opnd;
    logic [PW:0]   sum;

    // Resolve the selected operand and the pair add.
    always_comb begin
        sel_ok = (sel != PR_NONE);
        idx    = sel_ok ? sel : PR_BC;
        opnd   = cur[idx];
        sum    = {1'b0, cur[PR_HL]} + {1'b0, opnd};
    end

    // Decode the operation into pair write enables and next values.
    always_comb begin
        we     = '0;
        nxt    = cur;
        cy_we  = 1'b0;
        cy_val = 1'b0;
        unique case (op)
            OP_PUT:   if (sel_ok) begin we[idx] = 1'b1; nxt[idx] = wdata;            end
            OP_IMM:   if (sel_ok) begin we[idx] = 1'b1; nxt[idx] = {imm_hi, imm_lo}; end
            OP_INC:   if (sel_ok) begin we[idx] = 1'b1; nxt[idx] = opnd + PW'(1);    end
            OP_DEC:   if (sel_ok) begin we[idx] = 1'b1; nxt[idx] = opnd - PW'(1);    end
            OP_SWAP: begin
                we[PR_DE]  = 1'b1;
                we[PR_HL]  = 1'b1;
                nxt[PR_DE] = cur[PR_HL];
                nxt[PR_HL] = cur[PR_DE];
            end
            OP_ADDHL: if (sel_ok) begin
                we[PR_HL]  = 1'b1;
                nxt[PR_HL] = sum[PW-1:0];
                cy_we      = 1'b1;
                cy_val     = sum[PW];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/reg_bank.sv
// Storage for the accumulator and the three byte pairs. A pair write
// replaces the whole pair and beats a byte write into the same pair.
// Assumes byte code 2p is the high byte and 2p+1 the low byte of pair p.
module reg_bank
    import pair_regfile_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_sel,
    input  logic [W-1:0]                    wr_data,
    input  logic [NUM_PAIRS-1:0]            pair_we,
    input  logic [NUM_PAIRS-1:0][2*W-1:0]   pair_nxt,
    output logic [NUM_PAIRS-1:0][2*W-1:0]   pair_q,
    output logic [W-1:0]                    acc_q
);
    localparam int PW = 2 * W;

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          acc_q <= '0;
        else if (wr_en && wr_sel == SEL_ACC) acc_q <= wr_data;
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam logic [2:0] HI_CODE = 3'(2 * p);
        localparam logic [2:0] LO_CODE = 3'(2 * p + 1);
        logic [PW-1:0] r_q;

        // One pair: pair operation first, then a byte write.
        always_ff @(posedge clk) begin
            if (!rst_n)                          r_q <= '0;
            else if (pair_we[p])                 r_q <= pair_nxt[p];
            else if (wr_en && wr_sel == HI_CODE) r_q[PW-1:W] <= wr_data;
            else if (wr_en && wr_sel == LO_CODE) r_q[W-1:0]  <= wr_data;
        end
        assign pair_q[p] = r_q;

        // R10
        pair_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_we[p] && wr_en && (wr_sel == HI_CODE || wr_sel == LO_CODE))
            |=> pair_q[p] == $past(pair_nxt[p]));
    end

    // R2
    void_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_VOID && pair_we == '0)
        |=> ($stable(pair_q) && $stable(acc_q)));
endmodule

// File: rtl/mem_addr_sel.sv
// Memory address source select: H-L is the default pointer, B-C and
// D-E serve indirect accesses. Assumes code 3 falls back to H-L.
module mem_addr_sel
    import pair_regfile_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]                      mem_sel,
    input  logic [NUM_PAIRS-1:0][2*W-1:0]   pairs,
    output logic [2*W-1:0]                  addr
);
    // Pick the address pair.
    always_comb begin
        unique case (mem_sel)
            2'd1:    addr = pairs[PR_BC];
            2'd2:    addr = pairs[PR_DE];
            default: addr = pairs[PR_HL];
        endcase
    end
endmodule

// File: rtl/pair_regfile.sv
// Top of the paired register file: byte and pair read muxes, the pair
// operation unit, storage, the pair-add carry and the memory address.
// Assumes writes land at the clock edge and reads show stored state.
module pair_regfile
    import pair_regfile_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_rd_sel,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [1:0]        pair_rd_sel,
    output logic [PAIR_W-1:0] pair_rd_data,
    input  logic [2:0]        pair_op,
    input  logic [1:0]        pair_sel,
    input  logic [PAIR_W-1:0] pair_wr_data,
    input  logic [DATA_W-1:0] imm_lo,
    input  logic [DATA_W-1:0] imm_hi,
    input  logic [1:0]        mem_sel,
    output logic [PAIR_W-1:0] mem_addr,
    output logic              carry_out
);
    logic [NUM_PAIRS-1:0][PAIR_W-1:0] pairs;
    logic [NUM_PAIRS-1:0][PAIR_W-1:0] pair_nxt;
    logic [NUM_PAIRS-1:0]             pair_we;
    logic [DATA_W-1:0]                acc;
    logic                             cy_we;
    logic                             cy_val;
    pair_op_e                         op;
    logic [PAIR_W-1:0]                rd_pair;

    assign op = pair_op_e'(pair_op);

    pair_alu #(.W(DATA_W)) i_alu (
        .op(op), .sel(pair_sel), .cur(pairs), .imm_lo(imm_lo), .imm_hi(imm_hi),
        .wdata(pair_wr_data), .we(pair_we), .nxt(pair_nxt),
        .cy_we(cy_we), .cy_val(cy_val)
    );

    reg_bank #(.W(DATA_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
        .wr_data(reg_wr_data), .pair_we(pair_we), .pair_nxt(pair_nxt),
        .pair_q(pairs), .acc_q(acc)
    );

    mem_addr_sel #(.W(DATA_W)) i_mem (
        .mem_sel(mem_sel), .pairs(pairs), .addr(mem_addr)
    );

    // Carry flag, touched only by the pair add.
    always_ff @(posedge clk) begin
        if (!rst_n)     carry_out <= 1'b0;
        else if (cy_we) carry_out <= cy_val;
    end

    // Byte read mux: high byte on even codes, low byte on odd codes.
    always_comb begin
        rd_pair = (reg_rd_sel[2:1] == 2'd3) ? '0 : pairs[reg_rd_sel[2:1]];
        if (reg_rd_sel == SEL_ACC)       reg_rd_data = acc;
        else if (reg_rd_sel == SEL_VOID) reg_rd_data = '0;
        else if (!reg_rd_sel[0])         reg_rd_data = rd_pair[PAIR_W-1:DATA_W];
        else                             reg_rd_data = rd_pair[DATA_W-1:0];
    end

    // Pair read mux.
    always_comb begin
        pair_rd_data = (pair_rd_sel == PR_NONE) ? '0 : pairs[pair_rd_sel];
    end

    // R6
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SWAP) |=> (pairs[PR_HL] == $past(pairs[PR_DE]) &&
                             pairs[PR_DE] == $past(pairs[PR_HL])));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && pair_sel == PR_HL)
        |=> pairs[PR_HL] == PAIR_W'($past(pairs[PR_HL]) + 1'b1));

    // R8
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_ADDHL || pair_sel == PR_NONE) |=> $stable(carry_out));

    // R11
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel == PR_NONE && op != OP_SWAP && !reg_wr_en)
        |=> ($stable(pairs) && $stable(carry_out)));

    // R9
    mem_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel == 2'd2) |-> mem_addr == {i_bank.g_pair[1].r_q});
endmodule

// File: tb/test_pair_regfile.sv
module test_pair_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  reg_rd_sel;
    logic [7:0]  reg_rd_data;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_sel;
    logic [7:0]  reg_wr_data;
    logic [1:0]  pair_rd_sel;
    logic [15:0] pair_rd_data;
    logic [2:0]  pair_op;
    logic [1:0]  pair_sel;
    logic [15:0] pair_wr_data;
    logic [7:0]  imm_lo, imm_hi;
    logic [1:0]  mem_sel;
    logic [15:0] mem_addr;
    logic        carry_out;

    int total = 0;
    int bad   = 0;

    logic [7:0] mr [0:7];
    logic       mcar;

    pair_regfile i_pair_regfile (
        .clk(clk), .rst_n(rst_n), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .pair_rd_sel(pair_rd_sel), .pair_rd_data(pair_rd_data), .pair_op(pair_op),
        .pair_sel(pair_sel), .pair_wr_data(pair_wr_data), .imm_lo(imm_lo),
        .imm_hi(imm_hi), .mem_sel(mem_sel), .mem_addr(mem_addr), .carry_out(carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mpair(input int p);
        if (p == 3) return 16'h0000;
        return {mr[2*p], mr[2*p+1]};
    endfunction

    function automatic logic [15:0] maddr(input int s);
        if (s == 1) return mpair(0);
        if (s == 2) return mpair(1);
        return mpair(2);
    endfunction

    // Reference update from the requirements (R4..R8, R10, R11).
    task automatic model_apply(input logic we, input logic [2:0] ws, input logic [7:0] wd,
                               input logic [2:0] op, input logic [1:0] ps,
                               input logic [15:0] pw, input logic [7:0] lo, input logic [7:0] hi);
        logic [15:0] nv [0:2];
        logic        nw [0:2];
        logic [16:0] s;
        for (int p = 0; p < 3; p++) begin nv[p] = mpair(p); nw[p] = 1'b0; end
        case (op)
            3'd1: if (ps != 3) begin nw[ps] = 1; nv[ps] = pw; end
            3'd2: if (ps != 3) begin nw[ps] = 1; nv[ps] = {hi, lo}; end
            3'd3: begin nw[1] = 1; nw[2] = 1; nv[1] = mpair(2); nv[2] = mpair(1); end
            3'd4: if (ps != 3) begin nw[ps] = 1; nv[ps] = mpair(ps) + 16'd1; end
            3'd5: if (ps != 3) begin nw[ps] = 1; nv[ps] = mpair(ps) - 16'd1; end
            3'd6: if (ps != 3) begin
                s = {1'b0, mpair(2)} + {1'b0, mpair(ps)};
                nw[2] = 1; nv[2] = s[15:0]; mcar = s[16];
            end
            default: ;
        endcase
        if (we && ws == 3'd7) mr[7] = wd;
        else if (we && ws != 3'd6 && !nw[ws >> 1]) mr[ws] = wd;
        for (int p = 0; p < 3; p++)
            if (nw[p]) begin mr[2*p] = nv[p][15:8]; mr[2*p+1] = nv[p][7:0]; end
    endtask

    // Compare every read port against the reference.
    task automatic check_all(input string tag);
        for (int r = 0; r < 8; r++) begin
            reg_rd_sel = 3'(r); #1;
            chk({tag, " R2 reg read"}, {8'h00, reg_rd_data}, {8'h00, mr[r]});
        end
        for (int p = 0; p < 4; p++) begin
            pair_rd_sel = 2'(p); #1;
            chk({tag, " R4 pair read"}, pair_rd_data, mpair(p));
        end
        for (int m = 0; m < 4; m++) begin
            mem_sel = 2'(m); #1;
            chk({tag, " R9 mem addr"}, mem_addr, maddr(m));
        end
        chk({tag, " R8 carry"}, {15'd0, carry_out}, {15'd0, mcar});
    endtask

    task automatic step(input string tag, input logic we, input logic [2:0] ws,
                        input logic [7:0] wd, input logic [2:0] op, input logic [1:0] ps,
                        input logic [15:0] pw, input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        reg_wr_en = we; reg_wr_sel = ws; reg_wr_data = wd;
        pair_op = op; pair_sel = ps; pair_wr_data = pw; imm_lo = lo; imm_hi = hi;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; pair_op = 3'd0;
        model_apply(we, ws, wd, op, ps, pw, lo, hi);
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; reg_rd_sel = 0; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0;
        pair_rd_sel = 0; pair_op = 0; pair_sel = 0; pair_wr_data = 0;
        imm_lo = 0; imm_hi = 0; mem_sel = 0;
        for (int i = 0; i < 8; i++) mr[i] = 8'h00;
        mcar = 1'b0;
        // Load garbage during reset; R1 says reset wins.
        @(negedge clk); reg_wr_en = 1; reg_wr_sel = 3'd7; reg_wr_data = 8'hAA; pair_op = 3'd1; pair_sel = 2'd0; pair_wr_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        reg_wr_en = 0; pair_op = 0; rst_n = 1'b1;
        check_all("R1 reset");

        // R2 byte writes and the void code
        step("R2 write B", 1, 3'd0, 8'h12, 0, 0, 0, 0, 0);
        step("R2 write A", 1, 3'd7, 8'h9C, 0, 0, 0, 0, 0);
        step("R2 write L", 1, 3'd5, 8'h34, 0, 0, 0, 0, 0);
        step("R2 void write", 1, 3'd6, 8'hFF, 0, 0, 0, 0, 0);
        // R3 move C <- A, source unchanged
        reg_rd_sel = 3'd7; #1; v = reg_rd_data;
        step("R3 move", 1, 3'd1, v, 0, 0, 0, 0, 0);
        reg_rd_sel = 3'd7; #1; chk("R3 source kept", {8'h00, reg_rd_data}, 16'h009C);
        // R5 immediate byte order
        step("R5 load imm", 0, 0, 0, 3'd2, 2'd0, 0, 8'h00, 8'hD5);
        reg_rd_sel = 3'd0; #1; chk("R5 high byte", {8'h00, reg_rd_data}, 16'h00D5);
        reg_rd_sel = 3'd1; #1; chk("R5 low byte", {8'h00, reg_rd_data}, 16'h0000);
        // R4 pair write then R7 steps and wraps
        step("R4 put HL", 0, 0, 0, 3'd1, 2'd2, 16'hF050, 0, 0);
        step("R7 inc", 0, 0, 0, 3'd4, 2'd2, 0, 0, 0);
        pair_rd_sel = 2'd2; #1; chk("R7 inc value", pair_rd_data, 16'hF051);
        step("R7 dec", 0, 0, 0, 3'd5, 2'd2, 0, 0, 0);
        step("R7 dec", 0, 0, 0, 3'd5, 2'd2, 0, 0, 0);
        pair_rd_sel = 2'd2; #1; chk("R7 dec value", pair_rd_data, 16'hF04F);
        step("R4 put DE", 0, 0, 0, 3'd1, 2'd1, 16'hFFFF, 0, 0);
        step("R7 wrap up", 0, 0, 0, 3'd4, 2'd1, 0, 0, 0);
        pair_rd_sel = 2'd1; #1; chk("R7 wrap up value", pair_rd_data, 16'h0000);
        step("R7 wrap down", 0, 0, 0, 3'd5, 2'd1, 0, 0, 0);
        pair_rd_sel = 2'd1; #1; chk("R7 wrap down value", pair_rd_data, 16'hFFFF);
        // R6 swap
        step("R6 swap", 0, 0, 0, 3'd3, 2'd3, 0, 0, 0);
        pair_rd_sel = 2'd2; #1; chk("R6 HL after swap", pair_rd_data, 16'hFFFF);
        pair_rd_sel = 2'd1; #1; chk("R6 DE after swap", pair_rd_data, 16'hF04F);
        // R8 add with and without carry
        step("R8 put HL", 0, 0, 0, 3'd1, 2'd2, 16'h8000, 0, 0);
        step("R8 put BC", 0, 0, 0, 3'd1, 2'd0, 16'h8001, 0, 0);
        step("R8 add carry", 0, 0, 0, 3'd6, 2'd0, 0, 0, 0);
        chk("R8 carry set", {15'd0, carry_out}, 16'd1);
        step("R8 inc keeps carry", 0, 0, 0, 3'd4, 2'd0, 0, 0, 0);
        step("R8 add no carry", 0, 0, 0, 3'd6, 2'd2, 0, 0, 0);
        chk("R8 carry clear", {15'd0, carry_out}, 16'd0);
        // R10 collisions
        step("R10 inc vs H write", 1, 3'd4, 8'h55, 3'd4, 2'd2, 0, 0, 0);
        step("R10 swap vs E write", 1, 3'd3, 8'h77, 3'd3, 2'd0, 0, 0, 0);
        step("R10 HL op with B write", 1, 3'd0, 8'h66, 3'd5, 2'd2, 0, 0, 0);
        // R11 unused pair code
        step("R11 put none", 0, 0, 0, 3'd1, 2'd3, 16'h1234, 0, 0);
        step("R11 add none", 0, 0, 0, 3'd6, 2'd3, 0, 0, 0);
        step("R11 op 7", 0, 0, 0, 3'd7, 2'd2, 16'h4321, 8'h11, 8'h22);

        // Random phase
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            step("rand", 1'($urandom), 3'($urandom), 8'($urandom), 3'($urandom),
                 2'($urandom), 16'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule